// File: doc/BRIEF.md
# Serial GPIO shift-chain controller

This block runs a chain of daisy-chained serial shift-register expanders that carry up to 32 ports of 1 to 4 bits each. During a burst it clocks the static output level of every participating bit out on a serial data line. At the same time it captures the bit the chain returns for that position. After the last bit it pulses a load strobe so the expanders latch their outputs and take a fresh input sample. The serial clock is divided down from the system clock.

Bursts start in one of two ways. With auto-repeat set they run back to back, separated by a programmable gap. With a single-shot request, software triggers one burst, and the request clears itself once that burst is over, provided auto-repeat is off. A plain register port, with a one-cycle write and a combinational read, holds the settings, the per-port output configuration, the port-enable mask and the sampled input words. The register port and the serial pins are control-style signals: no valid/ready handshake applies, and a write always completes in the cycle it is presented.

Top module: `serial_io_chain`

Register word addresses:
- 0: configuration. [1:0] holds bits per port minus one, [2] is auto-repeat, [3] is the single-shot request and [15:8] is the gap.
- 1: divider [11:0].
- 2: port-enable mask, where bit n enables port n.
- 4+k: input word for bit index k. These words are read-only.
- 32+n: output configuration of port n. It has a 3-bit field per bit at [23:12], and bit 12+3k is the level of bit k.

All other bits read as zero.

## Requirements
- R1: After reset the serial clock is high, serial data and load strobe are low, and the configuration, divider, mask and input words all read 0.
- R2: A burst shifts the enabled ports in ascending port order and, within each port, bit 0 up to bit (width field), with serial data equal to bit 12+3k of that port's configuration word for bit k.
- R3: Ports whose mask bit is 0 contribute no serial clock pulses, so a burst carries exactly (enabled ports)×(width field+1) bits.
- R4: The serial clock idles high. Data changes only with its falling edge and is stable at its rising edge. The period is max(2, divider) system cycles, with the low phase lasting floor(period/2) cycles.
- R5: After the last bit the load strobe is high for exactly one serial period while the serial clock stays high.
- R6: Input word k bit n holds the level returned for port n bit k. The words change only in the cycle the load strobe falls, a read in mid-burst returns the previous burst's values, and writes to them are ignored.
- R7: Input bits of ports not enabled, or of bit indices at or above the current width, keep their previous value across a burst.
- R8: Writing 1 to the single-shot bit starts one burst. The bit clears when that burst's load strobe ends if auto-repeat is 0, stays set if auto-repeat is 1, and a configuration write in that same cycle takes precedence over the clear.
- R9: With auto-repeat set, bursts repeat. The first serial falling edge of the next burst comes (gap+1)×max(2, divider) system cycles after the load strobe falls, and clearing auto-repeat during the strobe stops further bursts.
- R10: Port configuration words read back only bits [23:12] of what was written, and the divider reads back only its low 12 bits.
- R11: A burst with an all-zero mask produces only the load strobe, with no serial clock pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| ser_clk | output | 1 | Serial shift clock, idles high |
| ser_dout | output | 1 | Serial output data to the chain |
| ser_load | output | 1 | Load strobe, one serial period after the last bit |
| ser_din | input | 1 | Serial input data returned by the chain |

## Verification
Two things can land on the same system clock edge: the hardware clearing the single-shot bit at the end of a burst, and a software write to the configuration word. The bench provokes this by timing a write from the rising load strobe so that it is sampled exactly one divider period later, on the edge where the strobe falls. It then expects the single-shot bit to read back as 1 and a second burst to follow. A second, milder overlap is a register read issued in mid-burst while input capture is in progress; that read must still return the previous snapshot.

// File: rtl/sgpio_chain_pkg.sv
package sgpio_chain_pkg;
  typedef enum logic [1:0] {CH_IDLE, CH_SHIFT, CH_LOAD, CH_GAP} chain_state_e;

  localparam int CFG_AUTO_BIT     = 2;
  localparam int CFG_SINGLE_BIT   = 3;
  localparam int CFG_GAP_LSB      = 8;
  localparam int SRC_LSB          = 12;
  localparam int SRC_BITS_PER_PIN = 3;

  localparam int REG_CFG     = 0;
  localparam int REG_DIV     = 1;
  localparam int REG_MASK    = 2;
  localparam int REG_IN_BASE = 4;
endpackage

// File: rtl/sgpio_chain_regs.sv
module sgpio_chain_regs
  import sgpio_chain_pkg::*;
#(
  parameter int NPORTS  = 32,
  parameter int MAXBITS = 4,
  parameter int DIV_W   = 12,
  parameter int GAP_W   = 8,
  parameter int AW      = 6,
  parameter int BW      = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [AW-1:0]                    addr,
  input  logic [31:0]                      wdata,
  output logic [31:0]                      rdata,
  input  logic                             commit,
  input  logic                             hw_clear,
  input  logic [MAXBITS-1:0][NPORTS-1:0]   shadow,
  output logic [BW-1:0]                    wm1,
  output logic                             auto_rep,
  output logic                             single,
  output logic [GAP_W-1:0]                 gap,
  output logic [DIV_W-1:0]                 div,
  output logic [NPORTS-1:0]                mask,
  output logic [NPORTS-1:0][MAXBITS-1:0]   out_lvl
);
  localparam int SRCW = SRC_BITS_PER_PIN * MAXBITS;

  logic [SRCW-1:0]                 src [NPORTS];
  logic [MAXBITS-1:0][NPORTS-1:0]  in_words;
  logic                            wr_cfg, wr_div, wr_mask;

  assign wr_cfg  = wr_en && (addr == AW'(REG_CFG));
  assign wr_div  = wr_en && (addr == AW'(REG_DIV));
  assign wr_mask = wr_en && (addr == AW'(REG_MASK));

  // Software write wins over the hardware single-shot clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wm1      <= '0;
      auto_rep <= 1'b0;
      single   <= 1'b0;
      gap      <= '0;
      div      <= '0;
      mask     <= '0;
      in_words <= '0;
    end else begin
      if (wr_cfg) begin
        wm1      <= wdata[BW-1:0];
        auto_rep <= wdata[CFG_AUTO_BIT];
        single   <= wdata[CFG_SINGLE_BIT];
        gap      <= wdata[CFG_GAP_LSB +: GAP_W];
      end else if (hw_clear) begin
        single <= 1'b0;
      end
      if (wr_div)  div  <= wdata[DIV_W-1:0];
      if (wr_mask) mask <= wdata[NPORTS-1:0];
      if (commit)  in_words <= shadow;
    end
  end

  for (genvar gp = 0; gp < NPORTS; gp++) begin : g_port
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        src[gp] <= '0;
      else if (wr_en && (addr == AW'(NPORTS + gp)))
        src[gp] <= wdata[SRC_LSB +: SRCW];
    end
    for (genvar gb = 0; gb < MAXBITS; gb++) begin : g_bit
      assign out_lvl[gp][gb] = src[gp][SRC_BITS_PER_PIN*gb];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == AW'(REG_CFG)) begin
      rdata[BW-1:0]                = wm1;
      rdata[CFG_AUTO_BIT]          = auto_rep;
      rdata[CFG_SINGLE_BIT]        = single;
      rdata[CFG_GAP_LSB +: GAP_W]  = gap;
    end
    if (addr == AW'(REG_DIV))  rdata[DIV_W-1:0]  = div;
    if (addr == AW'(REG_MASK)) rdata[NPORTS-1:0] = mask;
    for (int b = 0; b < MAXBITS; b++)
      if (addr == AW'(REG_IN_BASE + b)) rdata[NPORTS-1:0] = in_words[b];
    for (int p = 0; p < NPORTS; p++)
      if (addr == AW'(NPORTS + p)) rdata[SRC_LSB +: SRCW] = src[p];
  end

  assert_snapshot_only_at_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_words != $past(in_words)) |-> $past(commit))
    else $error("input words changed outside a burst commit");

  assert_single_clear_rule_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(single) |-> (!$past(auto_rep) || $past(wr_cfg)))
    else $error("single-shot cleared while auto-repeat set");
endmodule

// File: rtl/sgpio_chain_clkgen.sv
module sgpio_chain_clkgen #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             fall_ev,
  output logic             rise_ev
);
  logic [DIV_W-1:0] cnt, eff;

  assign eff = (div < DIV_W'(2)) ? DIV_W'(2) : div;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (cnt >= eff - 1'b1) cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end

  assign fall_ev = (cnt == '0);
  assign rise_ev = (cnt == (eff >> 1));
endmodule

// File: rtl/sgpio_chain_shifter.sv
module sgpio_chain_shifter
  import sgpio_chain_pkg::*;
#(
  parameter int NPORTS  = 32,
  parameter int MAXBITS = 4,
  parameter int GAP_W   = 8,
  parameter int BW      = 2,
  parameter int PW      = 5
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            fall_ev,
  input  logic                            rise_ev,
  input  logic [BW-1:0]                   wm1,
  input  logic                            auto_rep,
  input  logic                            single,
  input  logic [GAP_W-1:0]                gap,
  input  logic [NPORTS-1:0]               mask,
  input  logic [NPORTS-1:0][MAXBITS-1:0]  out_lvl,
  input  logic                            sdin,
  output logic                            sclk,
  output logic                            sdout,
  output logic                            sload,
  output logic                            commit,
  output logic                            hw_clear,
  output logic [MAXBITS-1:0][NPORTS-1:0]  shadow
);
  chain_state_e     st;
  logic [PW-1:0]    p;
  logic [BW-1:0]    b;
  logic             last;
  logic [GAP_W-1:0] gcnt;
  logic [PW:0]      first_hit, after_hit;

  // Lowest enabled port above 'from' (or any when from_start); MSB = found.
  function automatic logic [PW:0] next_port(input logic [NPORTS-1:0] m,
                                            input logic [PW-1:0] from,
                                            input logic from_start);
    logic [PW:0] r;
    r = '0;
    for (int i = NPORTS - 1; i >= 0; i--)
      if (m[i] && (from_start || i > int'(from))) r = {1'b1, PW'(i)};
    return r;
  endfunction

  assign first_hit = next_port(mask, '0, 1'b1);
  assign after_hit = next_port(mask, p, 1'b0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= CH_IDLE;
      sclk   <= 1'b1;
      sdout  <= 1'b0;
      sload  <= 1'b0;
      p      <= '0;
      b      <= '0;
      last   <= 1'b0;
      gcnt   <= '0;
      shadow <= '0;
    end else begin
      case (st)
        CH_IDLE, CH_GAP: if (fall_ev) begin
          if (st == CH_GAP && gcnt != gap) begin
            gcnt <= gcnt + 1'b1;
          end else if (auto_rep || single) begin
            if (first_hit[PW]) begin
              p     <= first_hit[PW-1:0];
              b     <= '0;
              last  <= 1'b0;
              sdout <= out_lvl[first_hit[PW-1:0]][0];
              sclk  <= 1'b0;
              st    <= CH_SHIFT;
            end else begin
              sload <= 1'b1;
              st    <= CH_LOAD;
            end
          end else begin
            st <= CH_IDLE;
          end
        end
        CH_SHIFT: begin
          if (rise_ev) begin
            sclk         <= 1'b1;
            shadow[b][p] <= sdin;
            if (b >= wm1) begin
              if (after_hit[PW]) begin
                p <= after_hit[PW-1:0];
                b <= '0;
              end else begin
                last <= 1'b1;
              end
            end else begin
              b <= b + 1'b1;
            end
          end
          if (fall_ev) begin
            if (last) begin
              sload <= 1'b1;
              st    <= CH_LOAD;
            end else begin
              sdout <= out_lvl[p][b];
              sclk  <= 1'b0;
            end
          end
        end
        CH_LOAD: if (fall_ev) begin
          sload <= 1'b0;
          gcnt  <= '0;
          st    <= CH_GAP;
        end
        default: st <= CH_IDLE;
      endcase
    end
  end

  assign commit   = (st == CH_LOAD) && fall_ev;
  assign hw_clear = commit && !auto_rep;

  assert_load_clk_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sload |-> sclk)
    else $error("serial clock low during load strobe");

  assert_data_stable_at_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(sdout))
    else $error("serial data moved on rising serial clock");
endmodule

// File: rtl/serial_io_chain.sv
module serial_io_chain
  import sgpio_chain_pkg::*;
#(
  parameter int NPORTS  = 32,
  parameter int MAXBITS = 4,
  parameter int DIV_W   = 12,
  parameter int GAP_W   = 8,
  localparam int AW     = $clog2(2 * NPORTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          ser_clk,
  output logic          ser_dout,
  output logic          ser_load,
  input  logic          ser_din
);
  localparam int BW = (MAXBITS > 1) ? $clog2(MAXBITS) : 1;
  localparam int PW = $clog2(NPORTS);

  logic [BW-1:0]                   wm1;
  logic                            auto_rep, single, commit, hw_clear;
  logic                            fall_ev, rise_ev;
  logic [GAP_W-1:0]                gap;
  logic [DIV_W-1:0]                div;
  logic [NPORTS-1:0]               mask;
  logic [NPORTS-1:0][MAXBITS-1:0]  out_lvl;
  logic [MAXBITS-1:0][NPORTS-1:0]  shadow;

  sgpio_chain_regs #(
    .NPORTS(NPORTS), .MAXBITS(MAXBITS), .DIV_W(DIV_W), .GAP_W(GAP_W), .AW(AW), .BW(BW)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .commit(commit), .hw_clear(hw_clear), .shadow(shadow),
    .wm1(wm1), .auto_rep(auto_rep), .single(single), .gap(gap), .div(div),
    .mask(mask), .out_lvl(out_lvl)
  );

  sgpio_chain_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .div(div), .fall_ev(fall_ev), .rise_ev(rise_ev)
  );

  sgpio_chain_shifter #(
    .NPORTS(NPORTS), .MAXBITS(MAXBITS), .GAP_W(GAP_W), .BW(BW), .PW(PW)
  ) u_shifter (
    .clk(clk), .rst_n(rst_n), .fall_ev(fall_ev), .rise_ev(rise_ev), .wm1(wm1),
    .auto_rep(auto_rep), .single(single), .gap(gap), .mask(mask), .out_lvl(out_lvl),
    .sdin(ser_din), .sclk(ser_clk), .sdout(ser_dout), .sload(ser_load),
    .commit(commit), .hw_clear(hw_clear), .shadow(shadow)
  );
endmodule

// File: tb/serial_io_chain_bench.sv
module serial_io_chain_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ser_clk, ser_dout, ser_load;
  logic        ser_din = 1'b0;

  serial_io_chain u_serial_io_chain (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ser_clk(ser_clk),
    .ser_dout(ser_dout), .ser_load(ser_load), .ser_din(ser_din)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, loads = 0, bits_seen = 0, seed = 0;
  bit done = 1'b0;
  bit exp_q[$];
  bit in_q[$];
  int blen_q[$];
  bit out_model [32][4];
  bit exp_in    [4][32];
  bit exp_next  [4][32];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic bit pat(input int p, input int b);
    return ((p * 5 + b * 3 + seed) % 7) < 3;
  endfunction

  function automatic logic [31:0] word_of(input int b);
    logic [31:0] w;
    for (int p = 0; p < 32; p++) w[p] = exp_in[b][p];
    return w;
  endfunction

  // Driver: expected serial bits, returned input bits and burst length.
  task automatic expect_burst(input int wm1, input logic [31:0] m);
    int n;
    n = 0;
    for (int p = 0; p < 32; p++)
      if (m[p])
        for (int b = 0; b <= wm1; b++) begin
          exp_q.push_back(out_model[p][b]);
          in_q.push_back(pat(p, b));
          exp_next[b][p] = pat(p, b);
          n++;
        end
    blen_q.push_back(n);
  endtask

  task automatic wait_load();
    @(posedge ser_load);
    @(negedge ser_load);
    @(negedge clk);
  endtask

  task automatic check_words(input string req);
    logic [31:0] d;
    exp_in = exp_next;
    for (int b = 0; b < 4; b++) begin
      rd(6'(4 + b), d);
      chk(req, $sformatf("input word %0d", b), d, word_of(b));
    end
  endtask

  // Monitor: serial data against the scoreboard at each rising serial clock.
  initial forever begin
    bit e;
    @(posedge ser_clk);
    #1;
    if (rst_n) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 unexpected serial bit: actual %0b expected none", ser_dout);
      end else begin
        e = exp_q.pop_front();
        chk("R2", "serial bit", 32'(ser_dout), 32'(e));
      end
      bits_seen++;
    end
  end

  // Chain model: returns the next input bit on each falling serial clock.
  initial forever begin
    @(negedge ser_clk);
    if (in_q.size() > 0) ser_din = in_q.pop_front();
    else                 ser_din = 1'b0;
  end

  // Monitor: burst length and clock level at each load strobe.
  initial forever begin
    int n;
    @(posedge ser_load);
    if (rst_n) begin
      loads++;
      chk("R5", "serial clock high at load", 32'(ser_clk), 32'd1);
      n = (blen_q.size() > 0) ? blen_q.pop_front() : -1;
      chk("R3", "bits per burst", bits_seen, n);
      bits_seen = 0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, w;
    int t0, t1, t2, t3, t4, lb;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset serial clock", 32'(ser_clk), 32'd1);
    chk("R1", "reset serial data", 32'(ser_dout), 32'd0);
    chk("R1", "reset load", 32'(ser_load), 32'd0);
    rd(6'd0, d); chk("R1", "reset config", d, 32'd0);
    rd(6'd1, d); chk("R1", "reset divider", d, 32'd0);
    rd(6'd2, d); chk("R1", "reset mask", d, 32'd0);
    rd(6'd4, d); chk("R1", "reset input word", d, 32'd0);

    // Output configuration with junk outside the level bits.
    for (int p = 0; p < 32; p++) begin
      w = 32'h8000_2001;
      for (int b = 0; b < 4; b++) begin
        out_model[p][b] = ((p * 3 + b * 7 + 1) % 5) < 2;
        w[12 + 3 * b] = out_model[p][b];
      end
      wr(6'(32 + p), w);
      if (p == 5 || p == 30) begin
        rd(6'(32 + p), d);
        chk("R10", "port config readback", d, w & 32'h00FF_F000);
      end
    end
    wr(6'd1, 32'hFFFF_F004);
    rd(6'd1, d); chk("R10", "divider readback", d, 32'h0000_0004);

    // Full chain, four bits per port, single shot.
    wr(6'd2, 32'hFFFF_FFFF);
    seed = 1;
    expect_burst(3, 32'hFFFF_FFFF);
    wr(6'd0, 32'h0000_000B);
    wait_load();
    check_words("R6");
    rd(6'd0, d); chk("R8", "single shot self-clear", d, 32'h0000_0003);
    wr(6'd4, 32'hFFFF_FFFF);
    rd(6'd4, d); chk("R6", "input word write ignored", d, word_of(0));

    // Sparse mask, two bits per port, mid-burst snapshot.
    wr(6'd2, 32'h0F0F_00F3);
    seed = 2;
    expect_burst(1, 32'h0F0F_00F3);
    wr(6'd0, 32'h0000_0009);
    repeat (6) @(posedge ser_clk);
    rd(6'd4, d); chk("R6", "mid-burst snapshot", d, word_of(0));
    wait_load();
    check_words("R7");

    // Divider 5: phase and period, load length.
    wr(6'd1, 32'd5);
    wr(6'd2, 32'h0000_0005);
    seed = 3;
    expect_burst(0, 32'h0000_0005);
    wr(6'd0, 32'h0000_0008);
    @(negedge ser_clk); @(negedge clk); t0 = cyc;
    @(posedge ser_clk); @(negedge clk); t1 = cyc;
    @(negedge ser_clk); @(negedge clk); t2 = cyc;
    chk("R4", "low phase div5", t1 - t0, 2);
    chk("R4", "period div5", t2 - t0, 5);
    @(posedge ser_load); @(negedge clk); t3 = cyc;
    @(negedge ser_load); @(negedge clk); t4 = cyc;
    chk("R5", "load strobe length", t4 - t3, 5);
    check_words("R6");

    // Divider below 2 is clamped.
    wr(6'd1, 32'd1);
    seed = 4;
    expect_burst(0, 32'h0000_0005);
    wr(6'd0, 32'h0000_0008);
    @(negedge ser_clk); @(negedge clk); t0 = cyc;
    @(negedge ser_clk); @(negedge clk); t2 = cyc;
    chk("R4", "period clamped to 2", t2 - t0, 2);
    wait_load();
    check_words("R6");

    // Empty mask: strobe only.
    wr(6'd1, 32'd4);
    wr(6'd2, 32'h0);
    lb = loads;
    expect_burst(0, 32'h0);
    wr(6'd0, 32'h0000_0008);
    wait_load();
    chk("R11", "empty burst load count", loads, lb + 1);
    check_words("R7");

    // Auto repeat with gap 2.
    wr(6'd2, 32'h0000_0003);
    seed = 5;
    expect_burst(0, 32'h0000_0003);
    expect_burst(0, 32'h0000_0003);
    lb = loads;
    wr(6'd0, 32'h0000_020C);
    wait_load(); t0 = cyc;
    @(negedge ser_clk); @(negedge clk); t1 = cyc;
    chk("R9", "gap to next burst", t1 - t0, 12);
    rd(6'd0, d); chk("R8", "single shot kept with auto", d & 32'h8, 32'h8);
    @(posedge ser_load);
    wr(6'd0, 32'h0);
    repeat (120) @(negedge clk);
    chk("R9", "bursts stop after auto cleared", loads, lb + 2);
    check_words("R6");

    // Software write on the clearing edge.
    seed = 6;
    wr(6'd2, 32'h0000_0001);
    expect_burst(0, 32'h0000_0001);
    expect_burst(0, 32'h0000_0001);
    lb = loads;
    wr(6'd0, 32'h0000_0008);
    @(posedge ser_load);
    repeat (4) @(negedge clk);
    reg_wr = 1'b1; reg_addr = 6'd0; reg_wdata = 32'h0000_0008;
    @(negedge clk);
    reg_wr = 1'b0;
    rd(6'd0, d); chk("R8", "write beats hardware clear", d, 32'h0000_0008);
    wait_load();
    chk("R8", "second burst from colliding write", loads, lb + 2);
    rd(6'd0, d); chk("R8", "cleared after second burst", d, 32'h0);
    check_words("R6");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    done = 1'b1;
    $finish;
  end
endmodule